// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Write Protection

This core keeps calendar time as eight BCD bytes: seconds, minutes, hours, day of month, month, two-digit year, day of week and century. A one-pulse-per-second tick input advances the time. A host reaches the bytes through a byte-wide port with a 16-bit address and single-cycle read and write strobes. The serial link that would normally carry these accesses sits outside the core.

The time bytes are protected. A status byte holds two enable bits, and both must be armed by two status writes in a fixed order before any time byte can change. One more status write locks the bytes again. A clock-failure flag in the same status byte is raised by reset. It is cleared when software completes a time load, which ends with the century byte.

The hour byte has a mode bit. When the bit is set, hours run from 00 to 23. When it is clear, hours run 12, 01 … 11 with a separate afternoon flag. Month lengths and leap years follow the Gregorian rules, and the full year is the year byte plus one hundred times the century byte.

Top module: `bcd_rtc_core`

## Requirements
- R1: The time bytes sit at addresses 0x0030 to 0x0037, one byte each, in this order: seconds, minutes, hour, day of month, month, year, day of week, century. After reset they read 0x00, 0x00, 0x80, 0x01, 0x01, 0x00, 0x00, 0x20. Read data appears on `host_rdata` one cycle after the clock edge that samples `host_rd`, and it holds until the next read.
- R2: The status byte at 0x003F reads as {5'b0, register-enable (bit 2), latch-enable (bit 1), clock-fail (bit 0)}. It reads 0x01 after reset.
- R3: Writing 0x02 to the status byte sets latch-enable and clears register-enable. Writing 0x06 sets register-enable only if latch-enable is already set; if latch-enable is clear, both bits end up clear. Writing any other value, including 0x00, clears both bits.
- R4: A write to a time byte takes effect only while both enable bits are set. At any other time it is ignored.
- R5: Clock-fail is set by reset. It is cleared only by a write to the century byte (0x0037) while both enable bits are set. Status writes never change it.
- R6: On each tick, seconds count up in BCD and wrap from 0x59 to 0x00, carrying into minutes. Minutes wrap from 0x59 to 0x00 in the same way, carrying into the hour.
- R7: With hour bit 7 set (24-hour mode), bits 5:0 count BCD 00 to 23. The step from 23 to 00 carries into the day, and bit 7 is kept.
- R8: With hour bit 7 clear (12-hour mode), bits 4:0 hold BCD 01 to 12 and bit 5 is the afternoon flag. The hour goes from 12 to 01, and the step from 11 to 12 toggles bit 5. Only the step from 11 with bit 5 set (afternoon) to 12 carries into the day.
- R9: The day of month wraps to 0x01 after the last day of its month. February has 29 days when the full year is a Gregorian leap year. The month wraps from 0x12 to 0x01 and then carries into the year.
- R10: The year wraps from 0x99 to 0x00 and carries into the century, which wraps from 0x99 to 0x00.
- R11: Day of week is a plain binary value from 0 to 6. It advances by one, wrapping from 6 to 0, on every day carry. A write to it keeps only data bits 2:0.
- R12: Reads of any address other than 0x0030 to 0x0037 and 0x003F return 0x00. Writes to those addresses change nothing.
- R13: If an accepted time-byte write and a tick arrive in the same cycle, the write is stored and the tick is dropped. No other byte advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_addr | input | ADDR_W (16) | Byte address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |

## Verification
A write, a status change or a tick updates the state at the clock edge that samples the strobe. A read strobe issued in the following cycle returns that state one edge later. The bench therefore drives every strobe for exactly one cycle from a falling edge and samples read data at the next falling edge, where the registered result has settled. Calendar expectations come from a separate binary-count model in the bench, which is converted to BCD only for comparison. Month ends, leap and non-leap centuries, all 24 hours in both modes and a 130-tick run are each checked this way after a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W        = 8;
    localparam int NUM_TIME_REGS = 8;
    localparam int IDX_W         = $clog2(NUM_TIME_REGS);

    typedef logic [BYTE_W-1:0] byte_t;

    // Position of each time byte within its eight-byte window.
    typedef enum logic [IDX_W-1:0] {
        IX_SEC  = 3'd0,
        IX_MIN  = 3'd1,
        IX_HOUR = 3'd2,
        IX_MDAY = 3'd3,
        IX_MON  = 3'd4,
        IX_YEAR = 3'd5,
        IX_WDAY = 3'd6,
        IX_CENT = 3'd7
    } time_idx_e;

    typedef struct packed {
        byte_t sec;
        byte_t mins;
        byte_t hour;
        byte_t mday;
        byte_t mon;
        byte_t year;
        byte_t wday;
        byte_t cent;
    } rtc_time_t;

    typedef struct packed {
        logic reg_en;
        logic latch_en;
        logic fail;
    } rtc_status_t;

    localparam byte_t ARM_FIRST  = 8'h02;
    localparam byte_t ARM_SECOND = 8'h06;

    localparam int HOUR_MODE_BIT = 7;
    localparam int HOUR_PM_BIT   = 5;

    function automatic byte_t bcd_inc(byte_t v);
        byte_t r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(byte_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Gregorian leap test using the two BCD year bytes.
    function automatic logic is_leap(byte_t year, byte_t cent);
        logic [6:0] yb;
        logic [6:0] cb;
        yb = bcd_to_bin(year);
        cb = bcd_to_bin(cent);
        if (yb != 7'd0) return yb[1:0] == 2'b00;
        return cb[1:0] == 2'b00;
    endfunction

    function automatic byte_t month_len(byte_t mon, logic leap);
        byte_t n;
        case (mon)
            8'h02:                      n = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: n = 8'h30;
            default:                    n = 8'h31;
        endcase
        return n;
    endfunction

    // Returns {day_carry, next_hour_byte} for either hour mode.
    function automatic logic [BYTE_W:0] hour_step(byte_t h);
        byte_t inc;
        byte_t nh;
        logic  carry;
        nh    = h;
        carry = 1'b0;
        inc   = 8'h00;
        if (h[HOUR_MODE_BIT]) begin
            if (h[5:0] == 6'h23) begin
                nh[5:0] = 6'h00;
                carry   = 1'b1;
            end else begin
                inc     = bcd_inc({2'b00, h[5:0]});
                nh[5:0] = inc[5:0];
            end
        end else begin
            if (h[4:0] == 5'h12) begin
                nh[4:0] = 5'h01;
            end else if (h[4:0] == 5'h11) begin
                nh[4:0]          = 5'h12;
                nh[HOUR_PM_BIT]  = ~h[HOUR_PM_BIT];
                carry            = h[HOUR_PM_BIT];
            end else begin
                inc     = bcd_inc({3'b000, h[4:0]});
                nh[4:0] = inc[4:0];
            end
        end
        return {carry, nh};
    endfunction

    function automatic rtc_time_t reset_time(byte_t cent);
        rtc_time_t t;
        t.sec  = 8'h00;
        t.mins = 8'h00;
        t.hour = 8'h80;
        t.mday = 8'h01;
        t.mon  = 8'h01;
        t.year = 8'h00;
        t.wday = 8'h00;
        t.cent = cent;
        return t;
    endfunction

    function automatic byte_t time_byte(rtc_time_t t, logic [IDX_W-1:0] i);
        byte_t b;
        case (time_idx_e'(i))
            IX_SEC:  b = t.sec;
            IX_MIN:  b = t.mins;
            IX_HOUR: b = t.hour;
            IX_MDAY: b = t.mday;
            IX_MON:  b = t.mon;
            IX_YEAR: b = t.year;
            IX_WDAY: b = t.wday;
            IX_CENT: b = t.cent;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_guard.sv
module rtc_guard
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        st_wr,
    input  byte_t       st_wdata,
    input  logic        cent_loaded,
    output logic        unlocked,
    output rtc_status_t status
);

    rtc_status_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fail     <= 1'b1;
            st_q.latch_en <= 1'b0;
            st_q.reg_en   <= 1'b0;
        end else begin
            if (st_wr) begin
                if (st_wdata == ARM_FIRST) begin
                    st_q.latch_en <= 1'b1;
                    st_q.reg_en   <= 1'b0;
                end else if (st_wdata == ARM_SECOND && st_q.latch_en) begin
                    st_q.reg_en   <= 1'b1;
                end else begin
                    st_q.latch_en <= 1'b0;
                    st_q.reg_en   <= 1'b0;
                end
            end
            if (cent_loaded) st_q.fail <= 1'b0;
        end
    end

    assign unlocked = st_q.latch_en & st_q.reg_en;
    assign status   = st_q;

    // R3: register-enable can only rise while latch-enable was already set
    a_r3_second_needs_first: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.reg_en) |-> $past(st_q.latch_en));

    // R3: the second step without the first leaves register-enable clear
    a_r3_skip_stays_locked: assert property (@(posedge clk) disable iff (rst)
        (st_wr && st_wdata == ARM_SECOND && !st_q.latch_en) |=> !st_q.reg_en);

    // R5: clock-fail never rises outside reset
    a_r5_fail_no_rise: assert property (@(posedge clk) disable iff (rst)
        !$rose(st_q.fail));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter byte_t RST_CENT = 8'h20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  byte_t            wr_data,
    output rtc_time_t        now
);

    rtc_time_t cur;
    rtc_time_t nxt;

    logic          sec_wrap, min_wrap, day_wrap, mon_wrap, yr_wrap, cent_wrap;
    logic          hr_carry, leap;
    byte_t         hr_next;
    logic          adv_min, adv_hr, adv_day, adv_mon, adv_yr, adv_cent;

    always_comb begin
        {hr_carry, hr_next} = hour_step(cur.hour);
        leap      = is_leap(cur.year, cur.cent);
        sec_wrap  = cur.sec  == 8'h59;
        min_wrap  = cur.mins == 8'h59;
        day_wrap  = cur.mday == month_len(cur.mon, leap);
        mon_wrap  = cur.mon  == 8'h12;
        yr_wrap   = cur.year == 8'h99;
        cent_wrap = cur.cent == 8'h99;

        adv_min  = sec_wrap;
        adv_hr   = adv_min & min_wrap;
        adv_day  = adv_hr  & hr_carry;
        adv_mon  = adv_day & day_wrap;
        adv_yr   = adv_mon & mon_wrap;
        adv_cent = adv_yr  & yr_wrap;

        nxt     = cur;
        nxt.sec = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
        if (adv_min) nxt.mins = min_wrap ? 8'h00 : bcd_inc(cur.mins);
        if (adv_hr)  nxt.hour = hr_next;
        if (adv_day) begin
            nxt.mday = day_wrap ? 8'h01 : bcd_inc(cur.mday);
            nxt.wday = (cur.wday[2:0] >= 3'd6) ? 8'h00
                                               : {5'b0, cur.wday[2:0] + 3'd1};
        end
        if (adv_mon)  nxt.mon  = mon_wrap  ? 8'h01 : bcd_inc(cur.mon);
        if (adv_yr)   nxt.year = yr_wrap   ? 8'h00 : bcd_inc(cur.year);
        if (adv_cent) nxt.cent = cent_wrap ? 8'h00 : bcd_inc(cur.cent);
    end

    // A host write wins over a tick arriving in the same cycle (R13).
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= reset_time(RST_CENT);
        end else if (wr_en) begin
            case (time_idx_e'(wr_idx))
                IX_SEC:  cur.sec  <= wr_data;
                IX_MIN:  cur.mins <= wr_data;
                IX_HOUR: cur.hour <= wr_data;
                IX_MDAY: cur.mday <= wr_data;
                IX_MON:  cur.mon  <= wr_data;
                IX_YEAR: cur.year <= wr_data;
                IX_WDAY: cur.wday <= {5'b0, wr_data[2:0]};
                IX_CENT: cur.cent <= wr_data;
            endcase
        end else if (tick) begin
            cur <= nxt;
        end
    end

    assign now = cur;

    // R6: seconds wrap to zero on a tick
    a_r6_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cur.sec == 8'h59) |=> (cur.sec == 8'h00));

    // R10: year wrap moves the century
    a_r10_year_into_cent: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && adv_yr && cur.year == 8'h99)
            |=> (cur.year == 8'h00 && cur.cent != $past(cur.cent)));

    // R11: day of week stays within 0..6 across a carry from 6
    a_r11_wday_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && adv_day && cur.wday == 8'h06) |=> (cur.wday == 8'h00));

    // R13: write and tick together leave the seconds at the written value
    a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_en && wr_idx == IX_SEC) |=> (cur.sec == $past(wr_data)));

endmodule

// File: rtl/rtc_readmux.sv
module rtc_readmux
    import rtc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CLK_BASE  = 16'h0030,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h003F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  rtc_time_t         now,
    input  rtc_status_t       status,
    output byte_t             rdata
);

    byte_t sel;
    logic  hit;

    always_comb begin
        hit = 1'b0;
        sel = 8'h00;
        if (addr[ADDR_W-1:IDX_W] == CLK_BASE[ADDR_W-1:IDX_W]) begin
            hit = 1'b1;
            sel = time_byte(now, addr[IDX_W-1:0]);
        end else if (addr == STAT_ADDR) begin
            hit = 1'b1;
            sel = {5'b0, status};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= 8'h00;
        else if (rd) rdata <= sel;
    end

    // R12: unmapped reads return zero
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && !hit) |=> (rdata == 8'h00));

    // R1: read data holds between reads
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CLK_BASE  = 16'h0030,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h003F,
    parameter logic [7:0]        RST_CENT  = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);

    localparam int WIN_HI = ADDR_W - 1;

    logic        in_window;
    logic        unlocked;
    logic        time_wr_ok;
    logic        st_wr;
    logic        cent_loaded;
    rtc_status_t status;
    rtc_time_t   now_time;

    assign in_window   = host_addr[WIN_HI:IDX_W] == CLK_BASE[WIN_HI:IDX_W];
    assign time_wr_ok  = host_wr && in_window && unlocked;
    assign st_wr       = host_wr && (host_addr == STAT_ADDR);
    assign cent_loaded = time_wr_ok && (host_addr[IDX_W-1:0] == IX_CENT);

    rtc_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .st_wr       (st_wr),
        .st_wdata    (host_wdata),
        .cent_loaded (cent_loaded),
        .unlocked    (unlocked),
        .status      (status)
    );

    rtc_timekeeper #(
        .RST_CENT (RST_CENT)
    ) u_time (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .wr_en   (time_wr_ok),
        .wr_idx  (host_addr[IDX_W-1:0]),
        .wr_data (host_wdata),
        .now     (now_time)
    );

    rtc_readmux #(
        .ADDR_W    (ADDR_W),
        .CLK_BASE  (CLK_BASE),
        .STAT_ADDR (STAT_ADDR)
    ) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd     (host_rd),
        .addr   (host_addr),
        .now    (now_time),
        .status (status),
        .rdata  (host_rdata)
    );

    // R4: with no tick and no accepted write, the time bytes do not move
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !(host_wr && in_window && unlocked)) |=> $stable(now_time));

    // R4: a time write while locked leaves the seconds unchanged
    a_r4_locked_sec: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !unlocked && !tick_1hz) |=> $stable(now_time.sec));

endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;

    localparam logic [15:0] STAT = 16'h003F;
    localparam logic [15:0] BASE = 16'h0030;

    int checks = 0;
    int failures = 0;

    // Binary-count reference model
    int  m_s, m_m, m_h, m_d, m_mo, m_y, m_wd;
    bit  m_mil;

    always #4 clk = ~clk;

    bcd_rtc_core uut (
        .clk        (clk),
        .rst        (rst),
        .tick_1hz   (tick),
        .host_wr    (wr),
        .host_rd    (rd),
        .host_addr  (addr),
        .host_wdata (wdata),
        .host_rdata (rdata)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        bit lp;
        lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte();
        int h12;
        if (m_mil) return 8'h80 | bcd(m_h);
        h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
        return ((m_h >= 12) ? 8'h20 : 8'h00) | bcd(h12);
    endfunction

    function automatic logic [7:0] exp_byte(int i);
        case (i)
            0: return bcd(m_s);
            1: return bcd(m_m);
            2: return hour_byte();
            3: return bcd(m_d);
            4: return bcd(m_mo);
            5: return bcd(m_y % 100);
            6: return 8'(m_wd);
            default: return bcd(m_y / 100);
        endcase
    endfunction

    task automatic model_tick();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_m++;
            if (m_m == 60) begin
                m_m = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0; m_d++; m_wd = (m_wd + 1) % 7;
                    if (m_d > dim(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1; m_y = (m_y + 1) % 10000;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%02h expected=0x%02h", tag, what, act, exp);
        end
    endtask

    task automatic do_wr(logic [15:0] a, logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(logic [15:0] a, output logic [7:0] v);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic check_rd(string tag, logic [15:0] a, logic [7:0] exp);
        logic [7:0] v;
        do_rd(a, v);
        check(tag, $sformatf("addr 0x%04h", a), v, exp);
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 8; i++) check_rd(tag, BASE + 16'(i), exp_byte(i));
    endtask

    task automatic load_model();
        for (int i = 0; i < 8; i++) do_wr(BASE + 16'(i), exp_byte(i));
    endtask

    task automatic set_model(int y, int mo, int d, int h, int mi, int s, int wd, bit mil);
        m_y = y; m_mo = mo; m_d = d; m_h = h; m_m = mi; m_s = s; m_wd = wd; m_mil = mil;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int years[5];
        years = '{2023, 2024, 1900, 2000, 2100};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values, R2/R5 status after reset
        set_model(2000, 1, 1, 0, 0, 0, 0, 1'b1);
        check_all("R1");
        check_rd("R2", STAT, 8'h01);

        // R12 unmapped reads
        check_rd("R12", 16'h0038, 8'h00);
        check_rd("R12", 16'h003E, 8'h00);
        check_rd("R12", 16'h0130, 8'h00);
        check_rd("R12", 16'h102F, 8'h00);

        // R4 locked write ignored
        do_wr(BASE, 8'h45);
        check_rd("R4", BASE, 8'h00);

        // R3 second step without the first stays locked
        do_wr(STAT, 8'h06);
        check_rd("R3", STAT, 8'h01);
        do_wr(BASE, 8'h45);
        check_rd("R4", BASE, 8'h00);

        // R3 first step only: still locked for time bytes
        do_wr(STAT, 8'h02);
        check_rd("R3", STAT, 8'h03);
        do_wr(BASE + 16'd1, 8'h12);
        check_rd("R4", BASE + 16'd1, 8'h00);
        do_wr(STAT, 8'h06);
        check_rd("R3", STAT, 8'h07);

        // R4 accepted write, R5 fail only clears on century write
        do_wr(BASE, 8'h45);
        m_s = 45;
        check_rd("R4", BASE, 8'h45);
        check_rd("R5", STAT, 8'h07);
        do_wr(BASE + 16'd7, 8'h20);
        check_rd("R5", STAT, 8'h06);
        do_wr(STAT, 8'h02);
        check_rd("R5", STAT, 8'h02);
        do_wr(STAT, 8'h06);
        check_rd("R5", STAT, 8'h06);

        // R3 other value relocks
        do_wr(STAT, 8'h07);
        check_rd("R3", STAT, 8'h00);
        do_wr(BASE, 8'h11);
        check_rd("R4", BASE, 8'h45);
        do_wr(STAT, 8'h02);
        do_wr(STAT, 8'h06);
        check_rd("R3", STAT, 8'h06);

        // R6 seconds/minutes run across a day boundary
        set_model(2024, 2, 28, 23, 58, 0, 3, 1'b1);
        load_model();
        for (int t = 0; t < 130; t++) begin
            do_tick();
            model_tick();
            check_rd("R6", BASE, bcd(m_s));
            check_rd("R6", BASE + 16'd1, bcd(m_m));
        end
        check_all("R9");

        // R7 / R8 every hour in both modes
        for (int mil = 0; mil < 2; mil++) begin
            for (int h = 0; h < 24; h++) begin
                set_model(2030, 6, 15, h, 59, 59, 2, mil[0]);
                load_model();
                do_tick();
                model_tick();
                check_all(mil == 1 ? "R7" : "R8");
            end
        end

        // R9 / R11 month ends in leap and non-leap years
        foreach (years[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                set_model(years[k], mo, dim(mo, years[k]), 23, 59, 59, (mo + 3) % 7, 1'b1);
                load_model();
                do_tick();
                model_tick();
                check_all("R9");
            end
            set_model(years[k], 2, 28, 23, 59, 59, 6, 1'b1);
            load_model();
            do_tick();
            model_tick();
            check_all("R11");
        end

        // R10 year and century wraps
        set_model(2099, 12, 31, 23, 59, 59, 4, 1'b1);
        load_model();
        do_tick();
        model_tick();
        check_all("R10");
        set_model(9999, 12, 31, 23, 59, 59, 5, 1'b1);
        load_model();
        do_tick();
        model_tick();
        check_all("R10");

        // R11 day-of-week write keeps low three bits
        do_wr(BASE + 16'd6, 8'hFD);
        m_wd = 5;
        check_rd("R11", BASE + 16'd6, 8'h05);

        // R13 write and tick in the same cycle
        set_model(2040, 3, 10, 10, 20, 59, 1, 1'b1);
        load_model();
        tick = 1'b1; wr = 1'b1; addr = BASE; wdata = 8'h33;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        m_s = 33;
        check_all("R13");

        // R12 unmapped writes change nothing
        do_wr(16'h0038, 8'h55);
        do_wr(16'h1030, 8'h77);
        do_wr(16'h003E, 8'h11);
        check_all("R12");
        check_rd("R12", STAT, 8'h06);

        // R3 zero relocks
        do_wr(STAT, 8'h00);
        check_rd("R3", STAT, 8'h00);
        do_wr(BASE + 16'd1, 8'h44);
        check_rd("R4", BASE + 16'd1, bcd(m_m));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule